// File: doc/BRIEF.md
# Complementary Digital PWM Generator

This block produces a pulse-width-modulated level and its exact logical complement from a free-running period counter. A host writes two byte-wide registers through a synchronous write port made of an address, a data byte and a write strobe. One register holds the pulse-width code. The other selects 7-bit or 8-bit resolution, halves the counting rate, and carries a three-bit dead-time code that is passed through to a separate non-overlap stage.

Host writes land in a staging copy. The staged values become active only on the clock edge where the counter wraps to zero, so a period is never cut short or glitched by a mid-period update. The ends of the code range are pinned to steady DC levels for braking or DC drive. A one-cycle strobe marks the first cycle of every period for downstream logic.

Top module: `cpwm_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pwm_out` is 0, `pwm_out_n` is 1, `period_start` is 0 and `dead_code` is 0. Reset selects 8-bit resolution without the halving and a pulse-width code of 0.
- R2: With control bit 0 set (8-bit), `period_start` pulses every 256 cycles. With bit 0 clear (7-bit), it pulses every 128 cycles.
- R3: With control bit 5 set, the counter advances only every second clock, so the period doubles to 512 or 256 cycles and every high time doubles.
- R4: Pulse-width codes 0 and 1 hold `pwm_out` low for the whole period in either resolution.
- R5: The all-ones code for the active resolution (255 in 8-bit, 127 in 7-bit) holds `pwm_out` high for the whole period.
- R6: A code PW from 2 to 2^N-2 drives `pwm_out` high for the first PW counting steps of each period and low for the rest.
- R7: In 7-bit mode, any code with bit 7 set gives `pwm_out` high for the whole period.
- R8: `pwm_out_n` is the exact complement of `pwm_out` in every cycle.
- R9: Writes go to address 0 (pulse width) and address 1 (control). A written value changes no output until the next period starts: outputs and `dead_code` keep their previous behaviour for the rest of the current period.
- R10: `period_start` is high for exactly one cycle, in the first cycle of each period, while the counter is 0. `pwm_out` only rises in such a cycle.
- R11: `dead_code` shows control bits 3:1 of the active control setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the host port |
| wr_addr | input | 1 | Register select: 0 pulse width, 1 control |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Non-inverted PWM level |
| pwm_out_n | output | 1 | Complement of `pwm_out` |
| period_start | output | 1 | One-cycle strobe in the first cycle of a period |
| dead_code | output | 3 | Active dead-time code for the non-overlap stage |

## Verification
The bound checker watches several properties on every cycle. These are the complement relation, the single-cycle shape of the period strobe and its coincidence with a zero count, rises of the PWM level only at period start, a dead-time code that holds still between period boundaries, and the reset values. Exact period lengths, high-time counts per code, the halving, the 7-bit top-bit override and the deferral of a mid-period write depend on sequences of writes and counting. Only the bench's cycle-accurate reference model and its per-period measurements can show those.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    // Active control fields decoded from the control byte
    typedef struct packed {
        logic       div2;     // byte bit 5: count every second clock
        logic [2:0] dead;     // byte bits 3:1: dead-time code
        logic       res_full; // byte bit 0: 1 = full resolution
    } ctl_t;

    localparam int CTL_BIT_RES  = 0;
    localparam int CTL_BIT_DEAD = 1;
    localparam int CTL_BIT_DIV  = 5;

    localparam logic [2:0] DEAD_RST = 3'd0;

endpackage

// File: rtl/cpwm_hostregs.sv
module cpwm_hostregs
    import cpwm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output logic [DATA_W-1:0] act_pw,
    output ctl_t              act_ctl
);

    localparam logic [ADDR_W-1:0] ADDR_PW  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_CTL = ADDR_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] stg_pw;
        ctl_t              stg_ctl;
        logic [DATA_W-1:0] act_pw;
        ctl_t              act_ctl;
    } regs_t;

    localparam ctl_t CTL_RST = '{div2: 1'b0, dead: DEAD_RST, res_full: 1'b1};

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // Staged copies move into the active set only at a wrap
        if (load) begin
            r_d.act_pw  = r_q.stg_pw;
            r_d.act_ctl = r_q.stg_ctl;
        end
        if (wr_en) begin
            if (wr_addr == ADDR_PW) begin
                r_d.stg_pw = wr_data;
            end else if (wr_addr == ADDR_CTL) begin
                r_d.stg_ctl.res_full = wr_data[CTL_BIT_RES];
                r_d.stg_ctl.dead     = wr_data[CTL_BIT_DEAD +: 3];
                r_d.stg_ctl.div2     = wr_data[CTL_BIT_DIV];
            end
        end
        if (rst) begin
            r_d.stg_pw  = '0;
            r_d.stg_ctl = CTL_RST;
            r_d.act_pw  = '0;
            r_d.act_ctl = CTL_RST;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign act_pw  = r_q.act_pw;
    assign act_ctl = r_q.act_ctl;

endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div2,
    input  logic             res_full,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             strobe
);

    localparam logic [CNT_W-1:0] LAST_FULL  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LAST_SHORT = {1'b0, {(CNT_W-1){1'b1}}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
        logic             strobe;
    } tb_t;

    tb_t s_d, s_q;
    logic             tick;
    logic [CNT_W-1:0] last;

    always_comb begin
        tick = !div2 || s_q.phase;
        last = res_full ? LAST_FULL : LAST_SHORT;
        wrap = tick && (s_q.cnt == last);

        s_d        = s_q;
        s_d.strobe = 1'b0;
        if (wrap) begin
            s_d.cnt    = '0;
            s_d.phase  = 1'b0;
            s_d.strobe = 1'b1;
        end else begin
            if (tick) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
            s_d.phase = div2 ? !s_q.phase : 1'b0;
        end
        if (rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign cnt    = s_q.cnt;
    assign strobe = s_q.strobe;

endmodule

// File: rtl/cpwm_level.sv
module cpwm_level #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] pw,
    input  logic             res_full,
    output logic             level
);

    localparam int SHORT_W = CNT_W - 1;

    logic [CNT_W-1:0] code;
    logic             force_hi;

    always_comb begin
        if (res_full) begin
            code     = pw;
            force_hi = (pw == {CNT_W{1'b1}});
        end else begin
            code     = {1'b0, pw[SHORT_W-1:0]};
            force_hi = pw[CNT_W-1] || (pw[SHORT_W-1:0] == {SHORT_W{1'b1}});
        end

        if (force_hi) begin
            level = 1'b1;
        end else if (code <= CNT_W'(1)) begin
            level = 1'b0;
        end else begin
            level = (cnt < code);
        end
    end

endmodule

// File: rtl/cpwm_gen.sv
module cpwm_gen
    import cpwm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out,
    output logic              pwm_out_n,
    output logic              period_start,
    output logic [2:0]        dead_code
);

    logic [DATA_W-1:0] act_pw;
    ctl_t              act_ctl;
    logic [DATA_W-1:0] cnt_q;
    logic              wrap;
    logic              level;

    cpwm_hostregs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (wrap),
        .act_pw  (act_pw),
        .act_ctl (act_ctl)
    );

    cpwm_timebase #(.CNT_W(DATA_W)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .div2     (act_ctl.div2),
        .res_full (act_ctl.res_full),
        .cnt      (cnt_q),
        .wrap     (wrap),
        .strobe   (period_start)
    );

    cpwm_level #(.CNT_W(DATA_W)) u_lvl (
        .cnt      (cnt_q),
        .pw       (act_pw),
        .res_full (act_ctl.res_full),
        .level    (level)
    );

    assign pwm_out   = level;
    assign pwm_out_n = ~level;
    assign dead_code = act_ctl.dead;

endmodule

// File: rtl/cpwm_gen_chk.sv
module cpwm_gen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             pwm_out,
    input logic             pwm_out_n,
    input logic             period_start,
    input logic [2:0]       dead_code,
    input logic [CNT_W-1:0] cnt
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!pwm_out && pwm_out_n && !period_start && dead_code == 3'd0));

    // R8
    complement_chk: assert property (@(posedge clk) disable iff (rst)
        pwm_out_n == !pwm_out);

    // R10
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        period_start |=> !period_start);

    // R10
    strobe_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        period_start |-> (cnt == '0));

    // R10
    rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_out) |-> period_start);

    // R9
    dead_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !period_start |-> $stable(dead_code));

endmodule

bind cpwm_gen cpwm_gen_chk #(.CNT_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pwm_out      (pwm_out),
    .pwm_out_n    (pwm_out_n),
    .period_start (period_start),
    .dead_code    (dead_code),
    .cnt          (cnt_q)
);

// File: tb/test_cpwm_gen.sv
`timescale 1ns/1ps
module test_cpwm_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [0:0] wr_addr = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_out, pwm_out_n, period_start;
    logic [2:0] dead_code;

    always #2.5 clk = ~clk;

    cpwm_gen i_cpwm_gen (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .pwm_out      (pwm_out),
        .pwm_out_n    (pwm_out_n),
        .period_start (period_start),
        .dead_code    (dead_code)
    );

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R1";

    // Reference model state
    int m_cnt, m_phase, m_pw, m_ctl, h_pw, h_ctl, m_strobe;
    // Measurements from the outputs
    int cyc = 0, prev_start = -1, hi_cnt = 0, last_period = 0, last_high = 0;

    function automatic int exp_level(int cnt, int pw, int ctl);
        if (ctl & 1) begin
            if (pw == 255) return 1;
            if (pw <= 1) return 0;
            return (cnt < pw) ? 1 : 0;
        end
        if (pw >= 128 || pw == 127) return 1;
        if (pw <= 1) return 0;
        return (cnt < pw) ? 1 : 0;
    endfunction

    task automatic check(string req, string what, int got, int expv);
        vectors++;
        if (got != expv) begin
            miscompares++;
            $display("FAIL %s %s got %0d expected %0d at cycle %0d", req, what, got, expv, cyc);
        end
    endtask

    task automatic model_edge();
        int last, dv, tick;
        if (rst) begin
            m_cnt = 0; m_phase = 0; m_pw = 0; m_ctl = 1; h_pw = 0; h_ctl = 1; m_strobe = 0;
        end else begin
            last = (m_ctl & 1) ? 255 : 127;
            dv   = (m_ctl >> 5) & 1;
            tick = (dv == 0 || m_phase == 1) ? 1 : 0;
            if (tick == 1 && m_cnt == last) begin
                m_cnt = 0; m_phase = 0; m_strobe = 1; m_pw = h_pw; m_ctl = h_ctl;
            end else begin
                m_strobe = 0;
                if (tick == 1) m_cnt++;
                m_phase = dv ? 1 - m_phase : 0;
            end
            if (wr_en) begin
                if (wr_addr == 1'b0) h_pw = wr_data;
                else h_ctl = wr_data;
            end
        end
    endtask

    task automatic step();
        int e;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cyc++;
        e = exp_level(m_cnt, m_pw, m_ctl);
        check(cur_req, "pwm_out", pwm_out, e);
        check("R8", "pwm_out_n", pwm_out_n, 1 - e);
        check("R10", "period_start", period_start, m_strobe);
        check("R11", "dead_code", dead_code, (m_ctl >> 1) & 7);
        if (period_start) begin
            if (prev_start >= 0) begin
                last_period = cyc - prev_start;
                last_high   = hi_cnt;
            end
            prev_start = cyc;
            hi_cnt = 0;
        end
        hi_cnt += pwm_out;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write(bit a, int d);
        wr_en = 1'b1; wr_addr = a; wr_data = 8'(d);
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        #1000000;
        miscompares++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        cur_req = "R1";
        run(3);
        check("R1", "reset pwm_out", pwm_out, 0);
        check("R1", "reset pwm_out_n", pwm_out_n, 1);
        check("R1", "reset strobe", period_start, 0);
        rst = 1'b0;
        step();
        check("R1", "post-reset pwm_out", pwm_out, 0);
        check("R1", "post-reset dead_code", dead_code, 0);

        cur_req = "R4";
        run(600);
        check("R4", "high count pw=0", last_high, 0);
        check("R2", "8-bit period", last_period, 256);
        write(1'b0, 1);
        run(600);
        check("R4", "high count pw=1", last_high, 0);

        cur_req = "R6";
        write(1'b0, 64);
        run(600);
        check("R6", "high count pw=64", last_high, 64);
        write(1'b0, 2);
        run(600);
        check("R6", "high count pw=2", last_high, 2);
        write(1'b0, 254);
        run(600);
        check("R6", "high count pw=254", last_high, 254);

        cur_req = "R5";
        write(1'b0, 255);
        run(600);
        check("R5", "high count pw=255", last_high, 256);

        // Mid-period write must not act before the next period
        cur_req = "R9";
        write(1'b0, 40);
        run(600);
        while (!period_start) step();
        run(100);
        write(1'b0, 200);
        check("R9", "pwm_out after mid-period write", pwm_out, 0);
        write(1'b1, 8'h0B);
        check("R9", "dead_code after mid-period write", dead_code, 0);
        run(600);
        check("R11", "dead_code after period start", dead_code, 5);
        check("R9", "high count after deferred load", last_high, 200);

        cur_req = "R2";
        write(1'b1, 8'h00);
        write(1'b0, 100);
        run(500);
        check("R2", "7-bit period", last_period, 128);
        check("R6", "7-bit high count pw=100", last_high, 100);
        cur_req = "R5";
        write(1'b0, 127);
        run(400);
        check("R5", "7-bit high count pw=127", last_high, 128);
        cur_req = "R7";
        write(1'b0, 8'h85);
        run(400);
        check("R7", "7-bit top bit set", last_high, 128);
        cur_req = "R4";
        write(1'b0, 8'h01);
        run(400);
        check("R4", "7-bit high count pw=1", last_high, 0);

        cur_req = "R3";
        write(1'b1, 8'h21);
        write(1'b0, 10);
        run(1600);
        check("R3", "halved 8-bit period", last_period, 512);
        check("R3", "halved high count pw=10", last_high, 20);
        write(1'b1, 8'h20);
        write(1'b0, 30);
        run(900);
        check("R3", "halved 7-bit period", last_period, 256);
        check("R3", "halved 7-bit high count", last_high, 60);

        cur_req = "R1";
        rst = 1'b1;
        run(2);
        rst = 1'b0;
        step();
        check("R1", "re-reset pwm_out", pwm_out, 0);
        check("R1", "re-reset dead_code", dead_code, 0);
        cur_req = "R6";
        write(1'b0, 128);
        run(700);
        check("R6", "after reset high count pw=128", last_high, 128);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule